// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim and Complete

This block merges up to 31 level-sensitive interrupt sources into one external interrupt request for a single processor context. Each source has a small priority value, an enable bit and a pending bit. A context threshold gates the request: a source can raise it only when its priority is strictly above the threshold.

Software talks to the block through a word-addressed register port. The interrupt handler reads the claim register to learn which source to service. That read removes the source from the pending set. When the handler is done, it writes the same ID back to the same register. Until that write arrives, the source's level input cannot set its pending bit again. Software may also force a source pending by writing its pending bit. Source IDs start at 1, and ID 0 means "nothing to service".

Top module: `plic_lite`

## Requirements
- R1: After reset, every priority, pending, enable, in-service and threshold bit is 0, `irq_o` is low, and a claim read returns 0.
- R2: Source ID n (1..NSRC) has a PRIO_W-bit priority at word address n, and writes keep only the low PRIO_W bits. Word address 0 reads as 0 and ignores writes.
- R3: While source ID n is not in service, a high level on `src_i` bit n-1 sets pending bit n of the pending word (address 0x20) at the next clock edge. Bit 0 of that word always reads 0.
- R4: The enable word (address 0x21) holds one enable bit per source at bit n. A pending source whose enable bit is clear never raises `irq_o`.
- R5: `irq_o` is high exactly when some source is pending and enabled and its priority is strictly greater than the threshold (address 0x22). A threshold of 0 admits every nonzero priority. Priority 0 never interrupts, and the maximum threshold silences all sources.
- R6: A read of the claim word (address 0x23) returns the ID of the qualifying source with the highest priority. Among sources of equal priority, the lowest ID wins. The read returns 0 when no source qualifies.
- R7: A claim read that returns n clears pending bit n and marks n in service. Pending bit n is not set again by its input until n is written to address 0x23. After that write, a still-high input re-pends the source at the next edge.
- R8: Writing to address 0x23 an ID that is not in service has no effect on any pending bit.
- R9: A write to the pending word sets every pending bit whose data bit is 1. Data bits that are 0 clear nothing.
- R10: Read data appears on `rd_data` with `rd_valid` high in the cycle after the read request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Source levels; bit k is source ID k+1 |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | External interrupt request to the context |

## Verification
The bench builds the block with NSRC = 8 and the default 3-bit priority. With only eight sources, every pending and enable word can be written out by hand. This makes ties between equal priorities easy to set up, along with a priority-0 source that is pending and enabled, and a threshold at the priority maximum of 7. The same short run also covers the claim, the blocked re-pend and the completion of a source whose input is still held high.

// File: rtl/plic_lite.sv
module plic_lite #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              irq_o
);
  localparam int ID_W = $clog2(NSRC + 1);
  localparam logic [AW-1:0] A_PEND  = AW'(32);
  localparam logic [AW-1:0] A_EN    = AW'(33);
  localparam logic [AW-1:0] A_THR   = AW'(34);
  localparam logic [AW-1:0] A_CLAIM = AW'(35);

  logic [PRIO_W-1:0] prio_q [1:NSRC];
  logic [NSRC:1]     pend_q, en_q, busy_q;
  logic [PRIO_W-1:0] thr_q;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_p;
  logic [31:0]       rmux;

  wire wr       = req_valid && req_write;
  wire rd       = req_valid && !req_write;
  wire claim_rd = rd && req_addr == A_CLAIM;
  wire cmp_wr   = wr && req_addr == A_CLAIM;
  wire pend_wr  = wr && req_addr == A_PEND;

  always_comb begin
    best_id = '0;
    best_p  = thr_q;
    for (int i = 1; i <= NSRC; i++)
      if (pend_q[i] && en_q[i] && prio_q[i] > best_p) begin
        best_id = ID_W'(i);
        best_p  = prio_q[i];
      end
  end

  assign irq_o = best_id != '0;

  always_comb begin
    rmux = '0;
    for (int i = 1; i <= NSRC; i++)
      if (req_addr == AW'(i)) rmux = 32'(prio_q[i]);
    case (req_addr)
      A_PEND:  rmux = 32'({pend_q, 1'b0});
      A_EN:    rmux = 32'({en_q, 1'b0});
      A_THR:   rmux = 32'(thr_q);
      A_CLAIM: rmux = 32'(best_id);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      en_q     <= '0;
      busy_q   <= '0;
      thr_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      for (int i = 1; i <= NSRC; i++) prio_q[i] <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rmux;
      if (wr && req_addr == A_EN)  en_q  <= req_wdata[NSRC:1];
      if (wr && req_addr == A_THR) thr_q <= req_wdata[PRIO_W-1:0];
      for (int i = 1; i <= NSRC; i++) begin
        if (wr && req_addr == AW'(i)) prio_q[i] <= req_wdata[PRIO_W-1:0];
        if (claim_rd && best_id == ID_W'(i)) begin
          pend_q[i] <= 1'b0;
          busy_q[i] <= 1'b1;
        end else begin
          if ((src_i[i-1] && !busy_q[i]) || (pend_wr && req_wdata[i]))
            pend_q[i] <= 1'b1;
          if (cmp_wr && req_wdata == 32'(i))
            busy_q[i] <= 1'b0;
        end
      end
    end
  end

  AST_RD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write)); // R10
  AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(pend_q & en_q)); // R4
  AST_MAX_THR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> thr_q != '1); // R5
  AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(claim_rd) && rd_data != 0) |-> !pend_q[rd_data[ID_W-1:0]]); // R7
  AST_CLAIM_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(claim_rd) && rd_data != 0) |-> prio_q[rd_data[ID_W-1:0]] > thr_q); // R6
endmodule

// File: tb/sim_plic_lite.sv
module sim_plic_lite;
  localparam int NSRC = 8;
  localparam int AW   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, irq_o;
  logic [31:0] rd_data;

  int nchk = 0, nfail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  plic_lite #(.NSRC(NSRC), .PRIO_W(3), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o));

  always @(negedge clk) begin
    if (rd_valid) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R10: unexpected read data %h, expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          nfail++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    nchk++;
    if (irq_o !== e) begin
      nfail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b0, "R1 reset irq");
    rd(35, 0, "R1 reset claim");
    rd(1, 0, "R1 reset prio");
    rd(32, 0, "R1 reset pending");
    wr(3, 32'hD);
    rd(3, 5, "R2 prio keeps low bits");
    wr(0, 7);
    rd(0, 0, "R2 word 0 reads zero");
    src_i[2] = 1'b1;
    @(negedge clk);
    rd(32, 32'h8, "R3 level sets pending");
    chk_irq(1'b0, "R4 disabled source silent");
    wr(33, 32'h8);
    rd(33, 32'h8, "R4 enable readback");
    chk_irq(1'b1, "R4 enabled source raises irq");
    wr(34, 5);
    chk_irq(1'b0, "R5 equal to threshold blocked");
    wr(34, 4);
    chk_irq(1'b1, "R5 above threshold passes");
    wr(34, 0);
    rd(35, 3, "R6 claim returns id 3");
    chk_irq(1'b0, "R7 irq drops after claim");
    repeat (2) @(negedge clk);
    rd(32, 0, "R7 no re-pend while in service");
    rd(35, 0, "R6 claim zero when none");
    wr(35, 4);
    rd(32, 0, "R8 stray completion ignored");
    wr(35, 3);
    @(negedge clk);
    rd(32, 32'h8, "R7 re-pend after completion");
    chk_irq(1'b1, "R7 irq after re-pend");
    src_i[2] = 1'b0;
    rd(35, 3, "R6 claim id 3 again");
    wr(35, 3);
    rd(32, 0, "R7 quiet after release");
    wr(2, 4); wr(6, 4); wr(7, 2);
    wr(33, 32'hCC);
    wr(32, 32'hC4);
    rd(32, 32'hC4, "R9 software sets pending");
    rd(35, 2, "R6 tie goes to lowest id");
    rd(35, 6, "R6 next equal priority");
    rd(35, 7, "R6 lower priority last");
    rd(35, 0, "R6 all claimed");
    wr(35, 2); wr(35, 6); wr(35, 7);
    wr(33, 32'h20);
    wr(32, 32'h20);
    chk_irq(1'b0, "R5 priority zero never interrupts");
    rd(35, 0, "R5 priority zero not claimable");
    wr(32, 32'h0);
    rd(32, 32'h20, "R9 zero bits clear nothing");
    wr(5, 7); wr(34, 7);
    chk_irq(1'b0, "R5 max threshold silences");
    wr(34, 6);
    chk_irq(1'b1, "R5 prio 7 over threshold 6");
    rd(35, 5, "R6 claim id 5");
    wr(35, 5);
    repeat (3) @(negedge clk);
    nchk++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL R10: actual %0d reads outstanding expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_up();
  end
endmodule